// File: doc/BRIEF.md
# Filtered Non-Maskable Interrupt Detector

This block watches one asynchronous external pin and raises a non-maskable interrupt request when the pin is driven from high to low. The pin first goes through a two-flop synchroniser. It then passes a majority-free noise filter: the filter samples the pin at a rate chosen by a 3-bit select input and moves its output only when three samples in a row agree. A falling transition at the filter output sets a request flag. The flag stays set until the CPU side returns a one-cycle acknowledge.

The request path has no mask and no priority. Its only gate is an arm bit. Once the arm bit has been raised, lowering it again has no effect until the next reset. The filter and edge state reset to the low level, so an edge is counted only after the pin has been seen high since reset. A pin that is held low through reset therefore raises nothing.

Top module: `nmi_filter_detect`

## Requirements
- R1: While reset is asserted, and after it is released, `req_o` is 0. A pin held low through reset and kept low afterwards never sets `req_o`, even when the block is armed.
- R2: `req_o` is set only by a high-to-low change of the filtered pin while the block is armed. A pin that stays low after its request has been acknowledged sets nothing.
- R3: With `fsel_i` = 0 the filter is bypassed. A pin change driven before rising edge k reaches `req_o` at edge k+3, so `req_o` is still 0 after three edges and 1 after four. A single-cycle low pulse on the pin is enough to raise a request.
- R4: With `fsel_i` = n in 1..7 the pin is sampled every P = 2^(n-1) clocks, and the filter output moves only after three consecutive equal samples. A low pulse lasting 2P cycles never raises a request. A sustained low raises `req_o` no earlier than 2P+4 edges and no later than 3P+4 edges after the pin is driven.
- R5: While `en_i` has never been 1 since reset, falling transitions on the pin leave `req_o` at 0.
- R6: Once `en_i` has been 1 for one clock edge, the block stays armed until reset, whatever value `en_i` takes afterwards.
- R7: Once set, `req_o` stays 1 until a clock edge at which `ack_i` is 1. That edge clears it.
- R8: When an acknowledge and a new filtered falling transition arrive at the same edge, `req_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw asynchronous interrupt pin |
| fsel_i | input | 3 | Filter select: 0 bypasses the filter, n samples every 2^(n-1) clocks |
| en_i | input | 1 | Arm bit; sticky once seen high |
| ack_i | input | 1 | One-cycle acknowledge from the CPU side |
| req_o | output | 1 | Pending non-maskable request |

## Verification
The hardest case to reach from the ports is an acknowledge that lands on exactly the same edge as a fresh filtered falling transition. It needs a request that is still pending, a pin brought back high long enough for the filter to settle, and then a falling transition timed so that it reaches the edge detector in the acknowledge cycle. The bench uses the bypass setting, where the pin-to-flag delay is a fixed count of edges, and raises `ack_i` just before the edge on which that transition lands. The filter windows for every select value are checked with pulse lengths and wait times that the bench computes from the sample period.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned CNT_W = (1 << SEL_W) - 2;

  function automatic logic [CNT_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
    logic [CNT_W-1:0] m;
    for (int i = 0; i < CNT_W; i++) m[i] = (int'(sel) > i + 1);
    return m;
  endfunction
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_filter.sv
module nmi_filter
  import nmi_pkg::*;
#(
  parameter int unsigned VOTES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             d_i,
  output logic             q_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic             tick;
  logic [VOTES-1:0] hist_q;
  logic             filt_q;
  logic             bypass;

  assign mask   = div_mask(sel_i);
  assign tick   = (cnt_q & mask) == mask;
  assign bypass = (sel_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hist_q <= '0;
    else if (tick) hist_q <= {hist_q[VOTES-2:0], d_i};
  end

  // Output moves only on full agreement of the sample history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             filt_q <= 1'b0;
    else if (bypass)         filt_q <= d_i;
    else if (&hist_q)        filt_q <= 1'b1;
    else if (~|hist_q)       filt_q <= 1'b0;
  end

  assign q_o = filt_q;
endmodule

// File: rtl/nmi_req.sv
module nmi_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic filt_i,
  input  logic en_i,
  input  logic ack_i,
  output logic armed_o,
  output logic fall_o,
  output logic req_o
);
  logic prev_q;
  logic armed_q;
  logic req_q;
  logic fall;

  assign fall = prev_q & ~filt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      prev_q  <= filt_i;
      armed_q <= armed_q | en_i;
      // New edge wins over a simultaneous acknowledge
      req_q   <= (fall & armed_q) | (req_q & ~ack_i);
    end
  end

  assign armed_o = armed_q;
  assign fall_o  = fall;
  assign req_o   = req_q;
endmodule

// File: rtl/nmi_filter_detect.sv
module nmi_filter_detect
  import nmi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VOTES       = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [SEL_W-1:0] fsel_i,
  input  logic             en_i,
  input  logic             ack_i,
  output logic             req_o
);
  logic pin_sync_w;
  logic filt_w;
  logic armed_w;
  logic fall_w;

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync_w)
  );

  nmi_filter #(.VOTES(VOTES)) u_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (fsel_i),
    .d_i   (pin_sync_w),
    .q_o   (filt_w)
  );

  nmi_req u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .filt_i (filt_w),
    .en_i   (en_i),
    .ack_i  (ack_i),
    .armed_o(armed_w),
    .fall_o (fall_w),
    .req_o  (req_o)
  );
endmodule

// File: rtl/nmi_filter_detect_chk.sv
module nmi_filter_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic ack_i,
  input logic req_o,
  input logic armed,
  input logic fall
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o); // R7
  AST_ACK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i && !fall |=> !req_o); // R7
  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall && armed |=> req_o); // R8
  AST_NO_REQ_DISARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed && !req_o |=> !req_o); // R5
  AST_ARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> armed); // R6
  AST_ARM_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> armed); // R6
  AST_REQ_FROM_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(fall)); // R2
endmodule

bind nmi_filter_detect nmi_filter_detect_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .ack_i (ack_i),
  .req_o (req_o),
  .armed (armed_w),
  .fall  (fall_w)
);

// File: tb/nmi_filter_detect_tb.sv
module nmi_filter_detect_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin_i = 1'b0;
  logic [2:0] fsel_i = 3'd0;
  logic       en_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       req_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk_i = ~clk_i;

  nmi_filter_detect u_dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .fsel_i(fsel_i),
    .en_i  (en_i),
    .ack_i (ack_i),
    .req_o (req_o)
  );

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: req_o actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic ack_pulse();
    ack_i = 1'b1;
    step(1);
    ack_i = 1'b0;
  endtask

  initial begin
    // R1: reset with pin low, block idle
    @(negedge clk_i);
    step(3);
    chk("R1 during reset", req_o, 1'b0);
    rst_ni = 1'b1;
    step(2);
    chk("R1 after release", req_o, 1'b0);

    // R5: never armed, edges ignored
    pin_i = 1'b1; step(8);
    pin_i = 1'b0; step(8);
    chk("R5 disarmed edge", req_o, 1'b0);
    pin_i = 1'b1; step(8);
    pin_i = 1'b0; step(8);
    chk("R5 disarmed second edge", req_o, 1'b0);

    // R6: arm, then drop en_i
    en_i = 1'b1; step(1);
    en_i = 1'b0;
    pin_i = 1'b1; step(8);
    pin_i = 1'b0; step(4);
    chk("R6 sticky arm", req_o, 1'b1);
    ack_pulse();
    chk("R7 ack clears", req_o, 1'b0);

    // R1: pin low through reset, armed afterwards
    rst_ni = 1'b0; step(3);
    en_i = 1'b1;
    rst_ni = 1'b1; step(20);
    chk("R1 low at reset", req_o, 1'b0);

    // Sweep every filter setting
    for (int s = 0; s < 8; s++) begin
      int p;
      p = (s == 0) ? 0 : (1 << (s - 1));
      fsel_i = 3'(s);
      pin_i = 1'b1; step(3 * p + 8);
      chk("R2 idle high", req_o, 1'b0);
      if (s == 0) begin
        pin_i = 1'b0; step(1);
        pin_i = 1'b1; step(6);
        chk("R3 bypass passes 1-cycle pulse", req_o, 1'b1);
        ack_pulse();
        chk("R7 ack after pulse", req_o, 1'b0);
        pin_i = 1'b0; step(3);
        chk("R3 bypass not before edge k+3", req_o, 1'b0);
        step(1);
        chk("R3 bypass at edge k+3", req_o, 1'b1);
      end else begin
        pin_i = 1'b0; step(2 * p);
        pin_i = 1'b1; step(3 * p + 8);
        chk("R4 short pulse rejected", req_o, 1'b0);
        pin_i = 1'b0; step(2 * p + 4);
        chk("R4 not before earliest", req_o, 1'b0);
        step(p);
        chk("R4 by latest", req_o, 1'b1);
      end
      step(10);
      chk("R7 held without ack", req_o, 1'b1);
      ack_pulse();
      chk("R7 ack clears", req_o, 1'b0);
      step(3 * p + 8);
      chk("R2 steady low no request", req_o, 1'b0);
    end

    // R8: ack coincides with new edge
    fsel_i = 3'd0;
    pin_i = 1'b1; step(8);
    pin_i = 1'b0; step(6);
    chk("R8 first request", req_o, 1'b1);
    pin_i = 1'b1; step(8);
    chk("R7 still pending", req_o, 1'b1);
    pin_i = 1'b0; step(3);
    ack_i = 1'b1; step(1);
    ack_i = 1'b0;
    chk("R8 edge beats ack", req_o, 1'b1);
    ack_pulse();
    chk("R7 final ack", req_o, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule